// File: doc/BRIEF.md
# Parallel Display Bus Timing Engine

This block runs single transfers on an asynchronous 8080-style parallel bus that links a host to a display controller with its own frame memory. A transfer is a command write, a parameter/data write or a single read. Each one is a bus cycle whose chip-select, write-strobe and read-strobe edges sit at tick offsets the host programs. The tick is the system clock, optionally halved. A read samples the incoming bus at a programmed access tick and returns the value with a one-clock done pulse.

The host presents a command request, a data request or a read request, plus one write word. The timing words are packed fields; the engine latches them when it accepts a request. A busy flag covers the bus cycle and a following chip-select recovery gap. The engine drops requests that arrive while it is busy, and also drops every request while the divider or the timing fields break the legality rules. In that case it raises a configuration error flag.

Top module: `dbus_engine`

## Requirements
- R1: With no cycle in progress (busy low), cs_n, we_n and re_n are high, bus_oe is low and bus_out is zero. This is also the state after reset, where rd_done is low too.
- R2: clk_div set to 1 gives one tick per clock and 2 gives one tick per two clocks. Any other value raises cfg_err, and requests made while it is held are dropped.
- R3: cfg_err is raised, and requests are dropped, unless all of these hold: WE-off > WE-on, RE-off > RE-on, CS-off > CS-on, CS-off ≥ WE-off, CS-off ≥ RE-off, write cycle ≥ WE-off, read cycle ≥ RE-off, access > RE-on, access < read cycle.
- R4: A tick counter starts at 0 on the clock after a request is accepted. Each strobe is low while on ≤ count < off. CS acts in every cycle, WE only in write cycles and RE only in read cycles.
- R5: The active phase lasts the write cycle time (command/data) or the read cycle time (read), in ticks. It is followed by CS-pulse-width recovery ticks in which busy stays high and all strobes are high. A zero recovery width gives no recovery phase.
- R6: dc is 0 through a command cycle and its recovery, and 1 for data writes, reads and idle. bus_oe is high, with the write word on bus_out, for the whole active phase of a write cycle only.
- R7: In a read cycle, the clock edge that ends tick number `access` latches bus_in into rd_data. rd_done is high for exactly the one following clock.
- R8: With bus_wide low (8-bit bus), bus_out[15:8] is zero on writes and rd_data[15:8] is zero on reads. With bus_wide high, all 16 bits pass.
- R9: Requests made while busy are dropped and not queued. When more than one request is made in the same clock, command wins over data, and data wins over read.
- R10: Field positions. onoff_tim: CS-on [3:0], CS-off [9:4], WE-on [13:10], WE-off [19:14], RE-on [23:20], RE-off [29:24]. cycle_tim: write cycle [5:0], read cycle [11:6], CS pulse width [17:12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | 2 | Tick divider, legal values 1 and 2 |
| bus_wide | input | 1 | 1 selects a 16-bit bus, 0 an 8-bit bus |
| onoff_tim | input | 30 | Strobe edge offsets in ticks |
| cycle_tim | input | 18 | Write cycle, read cycle and CS recovery width in ticks |
| acc_time | input | 6 | Read sampling tick |
| cmd_wr | input | 1 | Command write request |
| param_wr | input | 1 | Parameter/data write request |
| rd_req | input | 1 | Single read request |
| wr_data | input | 16 | Word to write |
| bus_in | input | 16 | Data bus as seen from the panel side |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dc | output | 1 | 0 = command, 1 = data |
| bus_out | output | 16 | Data driven onto the bus |
| bus_oe | output | 1 | Output enable for bus_out |
| rd_data | output | 16 | Last word read |
| rd_done | output | 1 | One-clock pulse when rd_data updates |
| busy | output | 1 | Cycle or recovery in progress |
| cfg_err | output | 1 | Divider or timing fields illegal |

## Verification
Some rules hold on every clock and are checked as properties: the quiet bus whenever the engine is idle, the mutual exclusion of the write and read strobes, the output enable never overlapping a read strobe, a blocked configuration never starting a cycle, rd_done as a single pulse after busy, and the empty upper byte in 8-bit writes. Other behaviour is only visible from the bench's scenarios: the exact tick positions of each strobe edge under both dividers, the cycle and recovery lengths, the value latched at the access tick, request priority and the dropping of requests made while busy.

// File: rtl/dbus_pkg.sv
package dbus_pkg;

    localparam int ON_W    = 4;
    localparam int CNT_W   = 6;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int LANES   = DATA_W / BYTE_W;
    localparam int EDGE_W  = 3 * (ON_W + CNT_W);
    localparam int CYCW_W  = 3 * CNT_W;
    localparam int DIV_W   = 2;

    // strobe edge word, most significant field first
    typedef struct packed {
        logic [CNT_W-1:0] re_off;
        logic [ON_W-1:0]  re_on;
        logic [CNT_W-1:0] we_off;
        logic [ON_W-1:0]  we_on;
        logic [CNT_W-1:0] cs_off;
        logic [ON_W-1:0]  cs_on;
    } edge_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] cs_pw;
        logic [CNT_W-1:0] rd_cyc;
        logic [CNT_W-1:0] wr_cyc;
    } cyc_cfg_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_CMD  = 2'd1,
        OP_DAT  = 2'd2,
        OP_RD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACT  = 2'd1,
        PH_REC  = 2'd2
    } phase_e;

    function automatic logic in_window(input logic [CNT_W-1:0] cnt,
                                       input logic [ON_W-1:0]  on_t,
                                       input logic [CNT_W-1:0] off_t);
        return (cnt >= CNT_W'(on_t)) && (cnt < off_t);
    endfunction

    function automatic logic timing_legal(input edge_cfg_t e,
                                          input cyc_cfg_t c,
                                          input logic [CNT_W-1:0] acc);
        logic ok;
        ok = (e.we_off > CNT_W'(e.we_on));
        ok = ok && (e.re_off > CNT_W'(e.re_on));
        ok = ok && (e.cs_off > CNT_W'(e.cs_on));
        ok = ok && (e.cs_off >= e.we_off) && (e.cs_off >= e.re_off);
        ok = ok && (c.wr_cyc >= e.we_off);
        ok = ok && (c.rd_cyc >= e.re_off);
        ok = ok && (acc > CNT_W'(e.re_on)) && (acc < c.rd_cyc);
        return ok;
    endfunction

endpackage

// File: rtl/dbus_cfg_check.sv
module dbus_cfg_check
    import dbus_pkg::*;
(
    input  logic [DIV_W-1:0] clk_div,
    input  edge_cfg_t        edge_i,
    input  cyc_cfg_t         cyc_i,
    input  logic [CNT_W-1:0] acc_i,
    output logic             cfg_ok_o,
    output logic             div2_o
);

    logic div_legal;

    always_comb begin
        div_legal = (clk_div == DIV_W'(1)) || (clk_div == DIV_W'(2));
        div2_o    = (clk_div == DIV_W'(2));
        cfg_ok_o  = div_legal && timing_legal(edge_i, cyc_i, acc_i);
    end

endmodule

// File: rtl/dbus_tick_gen.sv
module dbus_tick_gen (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic div2,
    output logic tick
);

    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign tick = !div2 || phase_q;

endmodule

// File: rtl/dbus_seq.sv
module dbus_seq
    import dbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  op_e              start_op,
    input  logic             tick,
    input  logic [CNT_W-1:0] wr_cyc,
    input  logic [CNT_W-1:0] rd_cyc,
    input  logic [CNT_W-1:0] cs_pw,
    output phase_e           phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output op_e              op_o
);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    op_e              op_q;
    logic [CNT_W-1:0] act_len;

    assign act_len = (op_q == OP_RD) ? rd_cyc : wr_cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            op_q    <= OP_NONE;
        end else if (start) begin
            phase_q <= PH_ACT;
            cnt_q   <= '0;
            op_q    <= start_op;
        end else if (tick) begin
            case (phase_q)
                PH_ACT: begin
                    if (cnt_q == act_len - 1'b1) begin
                        cnt_q <= '0;
                        if (cs_pw != '0) begin
                            phase_q <= PH_REC;
                        end else begin
                            phase_q <= PH_IDLE;
                            op_q    <= OP_NONE;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_REC: begin
                    if (cnt_q == cs_pw - 1'b1) begin
                        cnt_q   <= '0;
                        phase_q <= PH_IDLE;
                        op_q    <= OP_NONE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign phase_o = phase_q;
    assign cnt_o   = cnt_q;
    assign op_o    = op_q;

endmodule

// File: rtl/dbus_engine.sv
module dbus_engine
    import dbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              bus_wide,
    input  logic [EDGE_W-1:0] onoff_tim,
    input  logic [CYCW_W-1:0] cycle_tim,
    input  logic [CNT_W-1:0]  acc_time,
    input  logic              cmd_wr,
    input  logic              param_wr,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] bus_in,
    output logic              cs_n,
    output logic              we_n,
    output logic              re_n,
    output logic              dc,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done,
    output logic              busy,
    output logic              cfg_err
);

    edge_cfg_t        edge_live, edge_q;
    cyc_cfg_t         cyc_live, cyc_q;
    logic [CNT_W-1:0] acc_q;
    logic             div2_live, div2_q;
    logic             wide_q;
    logic             cfg_ok;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] keep_live, keep_q;

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    op_e              op;
    op_e              req_op;
    logic             req_any, start, tick, active, is_write;

    assign edge_live = edge_cfg_t'(onoff_tim);
    assign cyc_live  = cyc_cfg_t'(cycle_tim);

    dbus_cfg_check u_cfg (
        .clk_div  (clk_div),
        .edge_i   (edge_live),
        .cyc_i    (cyc_live),
        .acc_i    (acc_time),
        .cfg_ok_o (cfg_ok),
        .div2_o   (div2_live)
    );

    // fixed priority: command, then data, then read
    always_comb begin
        req_any = cmd_wr || param_wr || rd_req;
        if (cmd_wr)        req_op = OP_CMD;
        else if (param_wr) req_op = OP_DAT;
        else               req_op = OP_RD;
    end

    assign busy  = (phase != PH_IDLE);
    assign start = !busy && cfg_ok && req_any;

    // byte lanes above lane 0 are only live on a wide bus
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign keep_live[g*BYTE_W +: BYTE_W] = {BYTE_W{(g == 0) || bus_wide}};
        assign keep_q[g*BYTE_W +: BYTE_W]    = {BYTE_W{(g == 0) || wide_q}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q  <= '0;
            cyc_q   <= '0;
            acc_q   <= '0;
            div2_q  <= 1'b0;
            wide_q  <= 1'b0;
            wdata_q <= '0;
        end else if (start) begin
            edge_q  <= edge_live;
            cyc_q   <= cyc_live;
            acc_q   <= acc_time;
            div2_q  <= div2_live;
            wide_q  <= bus_wide;
            wdata_q <= wr_data & keep_live;
        end
    end

    dbus_tick_gen u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .div2    (div2_q),
        .tick    (tick)
    );

    dbus_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .start_op (req_op),
        .tick     (tick),
        .wr_cyc   (cyc_q.wr_cyc),
        .rd_cyc   (cyc_q.rd_cyc),
        .cs_pw    (cyc_q.cs_pw),
        .phase_o  (phase),
        .cnt_o    (cnt),
        .op_o     (op)
    );

    assign active   = (phase == PH_ACT);
    assign is_write = (op == OP_CMD) || (op == OP_DAT);

    assign cs_n    = !(active && in_window(cnt, edge_q.cs_on, edge_q.cs_off));
    assign we_n    = !(active && is_write && in_window(cnt, edge_q.we_on, edge_q.we_off));
    assign re_n    = !(active && (op == OP_RD) && in_window(cnt, edge_q.re_on, edge_q.re_off));
    assign dc      = (op != OP_CMD);
    assign bus_oe  = active && is_write;
    assign bus_out = bus_oe ? wdata_q : '0;
    assign cfg_err = !cfg_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_done <= 1'b0;
        end else if (active && (op == OP_RD) && tick && (cnt == acc_q)) begin
            rd_data <= bus_in & keep_q;
            rd_done <= 1'b1;
        end else begin
            rd_done <= 1'b0;
        end
    end

endmodule

// File: rtl/dbus_engine_chk.sv
module dbus_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wide,
    input logic        cs_n,
    input logic        we_n,
    input logic        re_n,
    input logic [15:0] bus_out,
    input logic        bus_oe,
    input logic        rd_done,
    input logic        busy,
    input logic        cfg_err
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n && we_n && re_n && !bus_oe));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    // R6
    oe_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> re_n);

    // R3
    cfg_block_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && !busy) |=> !busy);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> $past(busy));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

    // R8
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && !bus_wide) |-> (bus_out[15:8] == 8'h00));

endmodule

bind dbus_engine dbus_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wide (bus_wide),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .re_n     (re_n),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .rd_done  (rd_done),
    .busy     (busy),
    .cfg_err  (cfg_err)
);

// File: tb/dbus_engine_tb.sv
`timescale 1ns/1ps
module dbus_engine_tb;

    localparam int CSON = 1, CSOFF = 8, WEON = 2, WEOFF = 6;
    localparam int REON = 2, REOFF = 7, WCYC = 9, RCYC = 10, ACC = 5;

    typedef struct packed {
        logic [1:0]  op;     // 1 cmd, 2 data, 3 read
        logic        wide;
        logic        div2;
        logic [5:0]  pw;
        logic [15:0] data;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b1, 1'b0, 6'd2, 16'hA5C3},
        '{2'd2, 1'b1, 1'b0, 6'd2, 16'h1234},
        '{2'd3, 1'b1, 1'b0, 6'd2, 16'hBEEF},
        '{2'd2, 1'b0, 1'b0, 6'd0, 16'hFF5A},
        '{2'd3, 1'b0, 1'b1, 6'd1, 16'hC35A},
        '{2'd1, 1'b1, 1'b1, 6'd0, 16'h0F0F},
        '{2'd3, 1'b1, 1'b1, 6'd0, 16'h8001}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  clk_div;
    logic        bus_wide;
    logic [29:0] onoff_tim;
    logic [17:0] cycle_tim;
    logic [5:0]  acc_time;
    logic        cmd_wr, param_wr, rd_req;
    logic [15:0] wr_data, bus_in;
    logic        cs_n, we_n, re_n, dc, bus_oe, rd_done, busy, cfg_err;
    logic [15:0] bus_out, rd_data;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dbus_engine u_dut (
        .clk(clk), .rst(rst), .clk_div(clk_div), .bus_wide(bus_wide),
        .onoff_tim(onoff_tim), .cycle_tim(cycle_tim), .acc_time(acc_time),
        .cmd_wr(cmd_wr), .param_wr(param_wr), .rd_req(rd_req),
        .wr_data(wr_data), .bus_in(bus_in),
        .cs_n(cs_n), .we_n(we_n), .re_n(re_n), .dc(dc),
        .bus_out(bus_out), .bus_oe(bus_oe), .rd_data(rd_data),
        .rd_done(rd_done), .busy(busy), .cfg_err(cfg_err)
    );

    // R10 field placement
    function automatic logic [29:0] mk_onoff(int cs_on, int cs_off, int we_on,
                                             int we_off, int re_on, int re_off);
        return {6'(re_off), 4'(re_on), 6'(we_off), 4'(we_on), 6'(cs_off), 4'(cs_on)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_cycle(input logic [1:0] op, input logic wide, input logic div2,
                             input logic [5:0] pw, input logic [15:0] data);
        int len   = (op == 2'd3) ? RCYC : WCYC;
        int dv    = div2 ? 2 : 1;
        int total = dv * (len + int'(pw));
        int dones = 0;
        logic [15:0] masked = wide ? data : {8'h00, data[7:0]};
        clk_div   = div2 ? 2'd2 : 2'd1;
        bus_wide  = wide;
        wr_data   = data;
        bus_in    = data;
        cycle_tim = {pw, 6'(RCYC), 6'(WCYC)};
        @(negedge clk);
        cmd_wr = (op == 2'd1); param_wr = (op == 2'd2); rd_req = (op == 2'd3);
        @(negedge clk);
        cmd_wr = 1'b0; param_wr = 1'b0; rd_req = 1'b0;
        for (int n = 0; n < total; n++) begin
            int k = n / dv;
            logic e_cs, e_we, e_re, e_oe;
            logic [31:0] ex, ac;
            if (k < len) begin
                e_cs = !(k >= CSON && k < CSOFF);
                e_we = !(op != 2'd3 && k >= WEON && k < WEOFF);
                e_re = !(op == 2'd3 && k >= REON && k < REOFF);
                e_oe = (op != 2'd3);
            end else begin
                e_cs = 1'b1; e_we = 1'b1; e_re = 1'b1; e_oe = 1'b0;
            end
            ex = {10'd0, 1'b1, e_cs, e_we, e_re, (op != 2'd1), e_oe, (e_oe ? masked : 16'h0)};
            ac = {10'd0, busy, cs_n, we_n, re_n, dc, bus_oe, bus_out};
            chk("R4 R5 R6 R8 strobe/bus in cycle", ac, ex);
            dones += int'(rd_done);
            @(negedge clk);
        end
        dones += int'(rd_done);
        chk("R1 R5 idle at cycle end", {27'd0, busy, cs_n, we_n, re_n, bus_oe}, 32'b01110);
        if (op == 2'd3) begin
            chk("R7 R8 read data", {16'h0, rd_data}, {16'h0, masked});
            chk("R7 one done pulse", 32'(dones), 32'd1);
        end else begin
            chk("R7 no done on write", 32'(dones), 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; clk_div = 2'd1; bus_wide = 1'b1;
        onoff_tim = mk_onoff(CSON, CSOFF, WEON, WEOFF, REON, REOFF);
        cycle_tim = {6'd2, 6'(RCYC), 6'(WCYC)};
        acc_time = 6'(ACC);
        cmd_wr = 1'b0; param_wr = 1'b0; rd_req = 1'b0;
        wr_data = 16'h0; bus_in = 16'h0;
        repeat (3) @(negedge clk);
        chk("R1 reset idle", {25'd0, busy, cs_n, we_n, re_n, bus_oe, rd_done, dc},
            32'b0111001);
        chk("R1 reset bus", {bus_out, rd_data}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 R3 legal config", {31'd0, cfg_err}, 32'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            run_cycle(VECS[i].op, VECS[i].wide, VECS[i].div2, VECS[i].pw, VECS[i].data);
        end

        // R2 illegal dividers
        for (int d = 0; d < 4; d += 3) begin
            clk_div = 2'(d);
            #1;
            chk("R2 bad divider flags", {31'd0, cfg_err}, 32'd1);
            @(negedge clk); cmd_wr = 1'b1;
            @(negedge clk); cmd_wr = 1'b0;
            chk("R2 bad divider drops request", {30'd0, busy, cs_n}, 32'b01);
        end
        clk_div = 2'd1;

        // R3 rule violations
        onoff_tim = mk_onoff(CSON, CSOFF, WEON, WEON, REON, REOFF);
        #1;
        chk("R3 we_off not after we_on", {31'd0, cfg_err}, 32'd1);
        @(negedge clk); param_wr = 1'b1;
        @(negedge clk); param_wr = 1'b0;
        chk("R3 illegal timing drops request", {30'd0, busy, bus_oe}, 32'b00);
        onoff_tim = mk_onoff(CSON, CSOFF, WEON, WEOFF, REON, REOFF);
        acc_time = 6'(REON);
        #1;
        chk("R3 access not after re_on", {31'd0, cfg_err}, 32'd1);
        acc_time = 6'(ACC);
        #1;
        chk("R3 restored config legal", {31'd0, cfg_err}, 32'd0);

        // R9 request while busy is dropped
        cycle_tim = {6'd0, 6'(RCYC), 6'(WCYC)};
        bus_wide = 1'b1; wr_data = 16'h4321;
        @(negedge clk); cmd_wr = 1'b1;
        @(negedge clk); cmd_wr = 1'b0;
        repeat (3) @(negedge clk);
        param_wr = 1'b1; wr_data = 16'h9999;
        @(negedge clk); param_wr = 1'b0;
        chk("R9 busy cycle unchanged", {15'd0, dc, bus_out}, {15'd0, 1'b0, 16'h4321});
        repeat (5) @(negedge clk);
        chk("R9 cycle ends on time", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R9 dropped request not queued", {31'd0, busy}, 32'd0);

        // R9 priority
        wr_data = 16'h7777;
        @(negedge clk); cmd_wr = 1'b1; rd_req = 1'b1; param_wr = 1'b1;
        @(negedge clk); cmd_wr = 1'b0; rd_req = 1'b0; param_wr = 1'b0;
        chk("R9 command wins", {14'd0, busy, dc, bus_oe, re_n, bus_out},
            {14'd0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h7777});
        repeat (12) @(negedge clk);
        wr_data = 16'h2222;
        @(negedge clk); param_wr = 1'b1; rd_req = 1'b1;
        @(negedge clk); param_wr = 1'b0; rd_req = 1'b0;
        chk("R9 data wins over read", {29'd0, dc, bus_oe, re_n}, 32'b111);
        repeat (12) @(negedge clk);
        chk("R1 quiet after tests", {28'd0, busy, cs_n, we_n, re_n}, 32'b0111);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule